// File: doc/BRIEF.md
# DDR Power-Up Initialization Sequencer

This block is the controller-side engine that takes a DDR graphics memory from power-on to a configured idle state. A one-cycle `start` pulse captures a configuration word (burst length code, burst type, read latency code and output driver strength). The block then runs a fixed sequence of commands on the memory's command and address pins. It first holds clock enable low while the supply and clock settle. It then raises clock enable and issues the commands that prepare the memory: a precharge of all banks, an extended mode write that turns the DLL on, a mode write that resets the DLL, a second precharge-all, the auto-refreshes, and a final mode write with the operating settings.

All waits are counted in clock cycles. The settling time is derived from a clock-frequency parameter (MHz) and a duration parameter (µs). The other waits are separate parameters: precharge recovery, mode-write recovery, refresh recovery and DLL lock. On every cycle that carries no sequence command, the block drives a no-op. When the last mode-write recovery has elapsed, `done` rises and stays high. The controller's normal traffic logic may take over the pins from then on.

The interface is control-only, with no data stream, so it has no valid/ready handshake. `start` is honoured only while the block is idle after reset, and the configuration is sampled in that same cycle.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is held and afterwards until `start` is seen, `cke` is 0, the command pins carry a no-op, `ba` and `addr` are 0, and `done` is 0.
- R2: After `start`, `cke` stays 0 for at least CLK_MHZ*STABLE_US cycles. It then rises, the next cycle is a no-op with `cke` high, and `cke` never falls again until reset.
- R3: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as no-op 0111, precharge 0010, auto-refresh 0001 and mode write 0000. Every cycle that is not a sequence command is a no-op, and no command other than a no-op appears while `cke` is 0.
- R4: The commands appear in this order: precharge-all, extended mode write, DLL-reset mode write, precharge-all, N_REF auto-refreshes, final mode write.
- R5: Each precharge-all drives `addr[8]`=1 and `ba`=0.
- R6: The extended mode write drives `ba`=01 and `addr[0]`=0 (DLL on). It places `cfg_drv[1]` on `addr[6]` and `cfg_drv[0]` on `addr[1]`, and all other address bits are 0.
- R7: Both main mode writes drive `ba`=00, with `cfg_bl` on `addr[2:0]`, `cfg_bt` on `addr[3]` and `cfg_cl` on `addr[6:4]`. `addr[8]` is 1 on the DLL-reset write and 0 on the final write, and all other bits are 0.
- R8: The command that follows a precharge comes at least T_RP cycles after it, and the one after a refresh at least T_RFC cycles after it. After a mode write the gap is at least T_MRD cycles, but after the DLL-reset mode write it is at least DLL_LOCK cycles.
- R9: `done` rises exactly T_MRD cycles after the final mode write and stays high with no-ops on the pins until reset.
- R10: Configuration inputs are sampled only in the `start` cycle. Later changes to them, and later `start` pulses, have no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the sequence (honoured only when idle) |
| cfg_bl | input | 3 | Burst length code for mode bits 2:0 |
| cfg_bt | input | 1 | Burst type for mode bit 3 |
| cfg_cl | input | 3 | Read latency code for mode bits 6:4 |
| cfg_drv | input | 2 | Driver strength, bit 1 to address bit 6, bit 0 to address bit 1 |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| done | output | 1 | Initialization complete |

## Verification
The hardest behaviour to reach from the ports is R10. It needs inputs that change while the long waits are running, and a stray `start` that arrives mid-sequence. The bench shortens the settling time through STABLE_US so that each run is a few hundred cycles. It sweeps every legal burst-length, burst-type and latency code, with all driver settings, and in every run it flips all configuration inputs and pulses `start` again after capture. A monitor timestamps every non-no-op command, and the bench compares the order, the address fields and the gaps with values computed from the parameters and from the configuration that was originally presented.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [1:0] {
    CMD_NOP,
    CMD_PRE,
    CMD_REF,
    CMD_MODE
  } cmd_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_WAIT,
    S_CKEUP,
    S_PRE1,
    S_EMRS,
    S_MRS_DLL,
    S_PRE2,
    S_REF,
    S_MRS_OP,
    S_DONE
  } state_e;

  typedef struct packed {
    logic [2:0] bl;
    logic       bt;
    logic [2:0] cl;
    logic [1:0] drv;
  } cfg_t;

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
  import ddr_init_pkg::*;
(
  input  cmd_e cmd,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  always_comb begin
    cs_n  = 1'b0;
    ras_n = 1'b1;
    cas_n = 1'b1;
    we_n  = 1'b1;
    case (cmd)
      CMD_PRE: begin
        ras_n = 1'b0;
        we_n  = 1'b0;
      end
      CMD_REF: begin
        ras_n = 1'b0;
        cas_n = 1'b0;
      end
      CMD_MODE: begin
        ras_n = 1'b0;
        cas_n = 1'b0;
        we_n  = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ddr_init_addr_gen.sv
module ddr_init_addr_gen
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2
) (
  input  state_e            state,
  input  cfg_t              cfg,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);
  always_comb begin
    ba   = '0;
    addr = '0;
    case (state)
      S_PRE1, S_PRE2: addr[8] = 1'b1;
      S_EMRS: begin
        ba[0]   = 1'b1;
        addr[1] = cfg.drv[0];
        addr[6] = cfg.drv[1];
      end
      S_MRS_DLL, S_MRS_OP: begin
        addr[2:0] = cfg.bl;
        addr[3]   = cfg.bt;
        addr[6:4] = cfg.cl;
        addr[8]   = (state == S_MRS_DLL);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int CLK_MHZ   = 200,
  parameter int STABLE_US = 200,
  parameter int T_RP      = 4,
  parameter int T_MRD     = 4,
  parameter int T_RFC     = 12,
  parameter int DLL_LOCK  = 200,
  parameter int N_REF     = 2,
  parameter int ADDR_W    = 12,
  parameter int BA_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        cfg_bl,
  input  logic              cfg_bt,
  input  logic [2:0]        cfg_cl,
  input  logic [1:0]        cfg_drv,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);
  localparam int STABLE_CYC = CLK_MHZ * STABLE_US;
  localparam int MAX_A   = (STABLE_CYC > DLL_LOCK) ? STABLE_CYC : DLL_LOCK;
  localparam int MAX_B   = (T_RFC > T_RP) ? T_RFC : T_RP;
  localparam int MAX_C   = (MAX_B > T_MRD) ? MAX_B : T_MRD;
  localparam int CNT_MAX = (MAX_A > MAX_C) ? MAX_A : MAX_C;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int REF_W   = $clog2(N_REF + 1);

  // A command in cycle t with wait load G-2 lets the next command land at t+G.
  localparam logic [CNT_W-1:0] LD_STABLE = CNT_W'(STABLE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_RP     = CNT_W'(T_RP - 2);
  localparam logic [CNT_W-1:0] LD_MRD    = CNT_W'(T_MRD - 2);
  localparam logic [CNT_W-1:0] LD_RFC    = CNT_W'(T_RFC - 2);
  localparam logic [CNT_W-1:0] LD_LOCK   = CNT_W'(DLL_LOCK - 2);

  state_e           state_q, ret_q;
  cfg_t             cfg_q;
  logic             cke_q;
  logic [REF_W-1:0] ref_left_q;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  cmd_e             cmd;

  always_comb begin
    tmr_load = 1'b1;
    tmr_val  = LD_MRD;
    case (state_q)
      S_IDLE:    begin tmr_load = start; tmr_val = LD_STABLE; end
      S_PRE1,
      S_PRE2:    tmr_val = LD_RP;
      S_MRS_DLL: tmr_val = LD_LOCK;
      S_REF:     tmr_val = LD_RFC;
      S_EMRS,
      S_MRS_OP:  tmr_val = LD_MRD;
      default:   tmr_load = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      ret_q      <= S_IDLE;
      cfg_q      <= '0;
      cke_q      <= 1'b0;
      ref_left_q <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start) begin
          cfg_q   <= '{bl: cfg_bl, bt: cfg_bt, cl: cfg_cl, drv: cfg_drv};
          state_q <= S_WAIT;
          ret_q   <= S_CKEUP;
        end
        S_WAIT: if (tmr_zero) begin
          state_q <= ret_q;
          if (ret_q == S_CKEUP) cke_q <= 1'b1;
        end
        S_CKEUP:   state_q <= S_PRE1;
        S_PRE1:    begin state_q <= S_WAIT; ret_q <= S_EMRS;    end
        S_EMRS:    begin state_q <= S_WAIT; ret_q <= S_MRS_DLL; end
        S_MRS_DLL: begin state_q <= S_WAIT; ret_q <= S_PRE2;    end
        S_PRE2: begin
          state_q    <= S_WAIT;
          ret_q      <= S_REF;
          ref_left_q <= REF_W'(N_REF);
        end
        S_REF: begin
          state_q    <= S_WAIT;
          ref_left_q <= ref_left_q - REF_W'(1);
          ret_q      <= (ref_left_q == REF_W'(1)) ? S_MRS_OP : S_REF;
        end
        S_MRS_OP:  begin state_q <= S_WAIT; ret_q <= S_DONE; end
        default:   state_q <= state_q;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      S_PRE1, S_PRE2:               cmd = CMD_PRE;
      S_REF:                        cmd = CMD_REF;
      S_EMRS, S_MRS_DLL, S_MRS_OP:  cmd = CMD_MODE;
      default:                      cmd = CMD_NOP;
    endcase
  end

  ddr_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  ddr_init_cmd_enc u_enc (
    .cmd   (cmd),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n)
  );

  ddr_init_addr_gen #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_addr (
    .state (state_q),
    .cfg   (cfg_q),
    .ba    (ba),
    .addr  (addr)
  );

  assign cke  = cke_q;
  assign done = (state_q == S_DONE);
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
  parameter int T_RP     = 4,
  parameter int T_MRD    = 4,
  parameter int T_RFC    = 12,
  parameter int DLL_LOCK = 200,
  parameter int ADDR_W   = 12,
  parameter int BA_W     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              done
);
  logic is_cmd, is_pre, is_ref, is_mode;
  int   since_q, req_q;
  logic have_prev_q;

  assign is_cmd  = !cs_n && !(ras_n && cas_n && we_n);
  assign is_pre  = !cs_n && !ras_n &&  cas_n && !we_n;
  assign is_ref  = !cs_n && !ras_n && !cas_n &&  we_n;
  assign is_mode = !cs_n && !ras_n && !cas_n && !we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_q     <= 0;
      req_q       <= 0;
      have_prev_q <= 1'b0;
    end else if (is_cmd) begin
      since_q     <= 1;
      have_prev_q <= 1'b1;
      if (is_pre)                                   req_q <= T_RP;
      else if (is_ref)                              req_q <= T_RFC;
      else if (is_mode && ba == '0 && addr[8])      req_q <= DLL_LOCK;
      else                                          req_q <= T_MRD;
    end else if (since_q < 1000000) begin
      since_q <= since_q + 1;
    end
  end

  a_r2_cke_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);

  a_r3_cmd_needs_cke: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd |-> cke);

  a_r5_pre_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> addr[8]);

  a_r6_emrs_dll_on: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mode && ba[0]) |-> !addr[0]);

  a_r8_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd && have_prev_q) |-> (since_q >= req_q));

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !is_cmd);
endmodule

bind ddr_init_seq ddr_init_seq_chk #(
  .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC), .DLL_LOCK(DLL_LOCK),
  .ADDR_W(ADDR_W), .BA_W(BA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .done(done)
);

// File: tb/ddr_init_seq_bench.sv
`timescale 1ns/1ps
module ddr_init_seq_bench;
  localparam int CLK_MHZ = 200, STABLE_US = 2, T_RP = 4, T_MRD = 4, T_RFC = 12;
  localparam int DLL_LOCK = 200, N_REF = 2, ADDR_W = 12, BA_W = 2;
  localparam int STABLE_CYC = CLK_MHZ * STABLE_US;
  localparam int N_CMD = 5 + N_REF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] cfg_bl = '0, cfg_cl = '0;
  logic cfg_bt = 1'b0;
  logic [1:0] cfg_drv = '0;
  logic cke, cs_n, ras_n, cas_n, we_n, done;
  logic [BA_W-1:0] ba;
  logic [ADDR_W-1:0] addr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ddr_init_seq #(
    .CLK_MHZ(CLK_MHZ), .STABLE_US(STABLE_US), .T_RP(T_RP), .T_MRD(T_MRD),
    .T_RFC(T_RFC), .DLL_LOCK(DLL_LOCK), .N_REF(N_REF), .ADDR_W(ADDR_W), .BA_W(BA_W)
  ) u_ddr_init_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_bl(cfg_bl), .cfg_bt(cfg_bt),
    .cfg_cl(cfg_cl), .cfg_drv(cfg_drv), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pins();
    return {28'd0, cs_n, ras_n, cas_n, we_n};
  endfunction

  // Encodings from R3: NOP 0111, PRE 0010, REF 0001, MODE 0000.
  localparam int K_NOP = 7, K_PRE = 2, K_REF = 1, K_MODE = 0;

  task automatic run(input int bl, input int bt, input int cl, input int drv);
    int kind[16], tcyc[16], cadr[16], cba[16];
    int n = 0, low = 0, rise = -1, t = 0, donecyc = -1, bad = 0, fell = 0, idle_bad = 0;
    int exp_kind[N_CMD], emrs_exp, mrs_exp;
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    chk(cke == 0 && pins() == K_NOP && done == 0 && addr == 0 && ba == 0,
        "R1", "state in reset", pins(), K_NOP);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (cke || pins() != K_NOP || done || addr != 0 || ba != 0) idle_bad++;
    end
    chk(idle_bad == 0, "R1", "idle before start, bad cycles", idle_bad, 0);
    cfg_bl = 3'(bl); cfg_bt = 1'(bt); cfg_cl = 3'(cl); cfg_drv = 2'(drv);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cfg_bl = ~cfg_bl; cfg_bt = ~cfg_bt; cfg_cl = ~cfg_cl; cfg_drv = ~cfg_drv;
    while (t < 5000) begin
      if (t == 50 || t == STABLE_CYC + 20) start = 1'b1;
      else start = 1'b0;
      if (rise < 0) begin
        if (cke) rise = t; else low++;
      end else if (!cke) fell = 1;
      if (done) begin donecyc = t; break; end
      if (cs_n !== 1'b0) bad++;
      else if (pins() != K_NOP) begin
        if (!cke) bad++;
        if (n < 16) begin
          kind[n] = pins(); tcyc[n] = t; cadr[n] = int'(addr); cba[n] = int'(ba);
        end
        n++;
      end
      @(negedge clk);
      t++;
    end
    start = 1'b0;
    chk(low >= STABLE_CYC && low <= STABLE_CYC + 2, "R2", "cke low cycles", low, STABLE_CYC);
    chk(fell == 0, "R2", "cke fell after rising", fell, 0);
    chk(n == N_CMD, "R3", "command count", n, N_CMD);
    chk(bad == 0, "R3", "illegal or cke-low command cycles", bad, 0);
    if (n != N_CMD) return;
    chk(tcyc[0] == rise + 1, "R2", "first command after one NOP", tcyc[0], rise + 1);
    exp_kind[0] = K_PRE; exp_kind[1] = K_MODE; exp_kind[2] = K_MODE; exp_kind[3] = K_PRE;
    for (int i = 0; i < N_REF; i++) exp_kind[4 + i] = K_REF;
    exp_kind[N_CMD-1] = K_MODE;
    for (int i = 0; i < N_CMD; i++)
      chk(kind[i] == exp_kind[i], "R4", $sformatf("command %0d kind", i), kind[i], exp_kind[i]);
    chk(cba[1] == 1 && cba[2] == 0, "R4", "EMRS before MRS (bank)", cba[1], 1);
    chk(cadr[0][8] && cba[0] == 0, "R5", "first precharge-all addr", cadr[0], 256);
    chk(cadr[3][8] && cba[3] == 0, "R5", "second precharge-all addr", cadr[3], 256);
    emrs_exp = (((drv >> 1) & 1) << 6) | ((drv & 1) << 1);
    chk(cadr[1] == emrs_exp && cba[1] == 1, "R6", "extended mode addr", cadr[1], emrs_exp);
    mrs_exp = (cl << 4) | (bt << 3) | bl;
    chk(cadr[2] == (mrs_exp | 256) && cba[2] == 0, "R7", "DLL-reset mode addr", cadr[2], mrs_exp | 256);
    chk(cadr[N_CMD-1] == mrs_exp && cba[N_CMD-1] == 0, "R10", "final mode addr uses captured cfg",
        cadr[N_CMD-1], mrs_exp);
    chk(tcyc[1] - tcyc[0] >= T_RP, "R8", "gap PRE->EMRS", tcyc[1] - tcyc[0], T_RP);
    chk(tcyc[2] - tcyc[1] >= T_MRD, "R8", "gap EMRS->MRS", tcyc[2] - tcyc[1], T_MRD);
    chk(tcyc[3] - tcyc[2] >= DLL_LOCK, "R8", "gap DLL reset->PRE", tcyc[3] - tcyc[2], DLL_LOCK);
    chk(tcyc[4] - tcyc[3] >= T_RP, "R8", "gap PRE->REF", tcyc[4] - tcyc[3], T_RP);
    for (int i = 4; i < 4 + N_REF; i++)
      chk(tcyc[i+1] - tcyc[i] >= T_RFC, "R8", $sformatf("gap after refresh %0d", i - 4),
          tcyc[i+1] - tcyc[i], T_RFC);
    chk(donecyc - tcyc[N_CMD-1] == T_MRD, "R9", "done delay after final mode write",
        donecyc - tcyc[N_CMD-1], T_MRD);
    idle_bad = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!done || pins() != K_NOP || !cke) idle_bad++;
    end
    chk(idle_bad == 0, "R9", "done held with NOPs, bad cycles", idle_bad, 0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog: actual %0d expected %0d", 150000, 0);
    summary();
    $finish;
  end

  initial begin
    int k = 0;
    for (int bl = 1; bl <= 3; bl++)
      for (int bt = 0; bt <= 1; bt++)
        for (int cl = 4; cl <= 6; cl++) begin
          run(bl, bt, cl, k % 4);
          k++;
        end
    summary();
    $finish;
  end
endmodule